// File: doc/BRIEF.md
# Configuration-Space Indirect Access Gateway

This block sits behind a vendor-defined window of 32-bit registers in a device's configuration space. Host software uses that window to reach small internal memories that are not mapped directly. Several agents may share the window. To take ownership, an agent fetches a fresh tag from a self-incrementing counter, writes that tag into the ownership register, and reads it back. A matching readback means the agent holds the window. Writing zero gives it up again.

Once it holds the window, the agent picks an internal space and reads the support status back. It then runs single-word transfers through an address/flag register and a data register. The flag bit is the completion handshake, and its sense is opposite for the two kinds of transfer. A store is started with the flag at 1, and the block drops the flag to 0 when the store is done. A load is started with the flag at 0, and the block raises the flag to 1 once the data register holds the result.

One of the spaces is a claim domain. Each word in that domain acts as a lock: it can be taken with a nonzero tag and released with zero.

Every transfer finishes after a latency of 1 to 16 cycles, chosen by an input. The register port uses a valid/ready request. Every register read is answered one cycle after the request is accepted.

Top module: `cfgwin_gateway`

## Requirements
- R1: Each accepted read of the tag counter (byte offset 0x08) returns the current tag, zero-extended, and then advances it by one. The tag is 1 after reset, never reads as 0, and wraps from its all-ones value back to 1.
- R2: The ownership register (offset 0x0C) reads 0 after reset. A write while it holds 0 stores the written value, which reads back unchanged.
- R3: While the ownership register is nonzero, a nonzero write to it is ignored. A write of 0 always clears it.
- R4: A write to the space register (offset 0x04) stores bits [15:0] as the space number. A read returns that number in [15:0], zeros in [28:16], and a status in [31:29]. The status is 3'b001 for a supported space and 3'b000 for any other. With the default parameters, spaces 0, 1 and 2 are supported.
- R5: Writing the address/flag register (offset 0x10) with bit 31 set starts a store of the data register (offset 0x14) to address bits [29:0] of the selected space. Bit 31 reads 1 while the store is pending and 0 after it completes.
- R6: Writing the address/flag register with bit 31 clear starts a load. Bit 31 reads 0 while the load is pending. It then reads 1, and the data register then holds the addressed word.
- R7: A transfer completes lat_cfg+1 clock edges after the edge that accepted its start. A read of the address/flag register accepted at that completion edge still shows the pending value.
- R8: In an unsupported space, stores are dropped and loads return 0. Both complete with the normal flag behaviour.
- R9: In the claim domain (space 2), a nonzero store over a nonzero word is ignored and a store of 0 frees the word. In an ordinary space, a store always overwrites.
- R10: While a transfer is pending, writes to the address/flag register and to the data register are ignored.
- R11: Each supported space has its own memory, so equal addresses in different spaces hold independent words. Only address bits [3:0] select a word by default.
- R12: `req_ready` is always 1. Each accepted read gets exactly one `rsp_valid` pulse on the following cycle, writes get none, and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lat_cfg | input | 4 | Transfer latency minus one |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request ready (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Read response data |

## Verification
Stores and loads are run in an ordinary space, in an unsupported space and in the claim domain, using the same address in each. This separates per-space storage, the zero-return path and the guarded-store rule.

The completion flag is polled on every cycle at the shortest, a middle and the longest latency. That pins the exact completion edge and the inverted flag sense for stores versus loads.

The ownership and claim locks are each taken, hit with a conflicting tag, and then released. The counter is read until it wraps, which shows the zero tag is skipped. Writes made while a transfer is pending are followed by reads of both registers and of the target word, which shows they had no effect.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
   localparam logic [7:0] OFF_SPACE = 8'h04;
   localparam logic [7:0] OFF_COUNT = 8'h08;
   localparam logic [7:0] OFF_OWNER = 8'h0C;
   localparam logic [7:0] OFF_XADDR = 8'h10;
   localparam logic [7:0] OFF_XDATA = 8'h14;

   localparam logic [2:0] ST_SUPPORTED   = 3'b001;
   localparam logic [2:0] ST_UNSUPPORTED = 3'b000;

   typedef enum logic [1:0] {
      XF_IDLE  = 2'd0,
      XF_STORE = 2'd1,
      XF_LOAD  = 2'd2
   } xfer_state_e;
endpackage

// File: rtl/cfgwin_lock.sv
module cfgwin_lock #(
   parameter int unsigned ID_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cnt_rd,
   input  logic            own_wr,
   input  logic [31:0]     own_wdata,
   output logic [ID_W-1:0] cnt_val,
   output logic [31:0]     own_val
);
   localparam logic [ID_W-1:0] CNT_TOP = '1;
   localparam logic [ID_W-1:0] CNT_ONE = ID_W'(1);

   if (ID_W < 2 || ID_W > 32) begin : g_bad_idw
      $error("cfgwin_lock: ID_W must lie in 2..32");
   end

   logic [ID_W-1:0] cnt_q;
   logic [31:0]     own_q;

   // Tag source: skips zero so a fetched tag can always take the lock.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= CNT_ONE;
      end else if (cnt_rd) begin
         cnt_q <= (cnt_q == CNT_TOP) ? CNT_ONE : cnt_q + CNT_ONE;
      end
   end

   // Ownership word: only an empty lock or a release is honoured.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         own_q <= '0;
      end else if (own_wr && (own_q == '0 || own_wdata == '0)) begin
         own_q <= own_wdata;
      end
   end

   assign cnt_val = cnt_q;
   assign own_val = own_q;

   p_tag_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q != '0);
   p_tag_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_rd |=> $stable(cnt_q));
   p_owner_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (own_wr && own_q != '0 && own_wdata != '0) |=> $stable(own_q));
   p_owner_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (own_wr && own_wdata == '0) |=> own_q == '0);
endmodule

// File: rtl/cfgwin_xfer.sv
module cfgwin_xfer
   import cfgwin_pkg::*;
#(
   parameter int unsigned MEM_AW  = 4,
   parameter int unsigned MAX_LAT = 16,
   localparam int unsigned LAT_W  = $clog2(MAX_LAT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LAT_W-1:0]  lat_cfg,
   input  logic              xa_wr,
   input  logic              xa_flag,
   input  logic [29:0]       xa_addr,
   input  logic              xd_wr,
   input  logic [31:0]       xd_wdata,
   input  logic [31:0]       mem_rdata,
   output logic              busy,
   output logic              mem_we,
   output logic [MEM_AW-1:0] mem_idx,
   output logic [31:0]       mem_wdata,
   output logic [31:0]       xa_view,
   output logic [31:0]       xd_view
);
   if (MAX_LAT < 2 || (1 << LAT_W) != MAX_LAT) begin : g_bad_lat
      $error("cfgwin_xfer: MAX_LAT must be a power of two >= 2");
   end
   if (MEM_AW < 1 || MEM_AW > 30) begin : g_bad_aw
      $error("cfgwin_xfer: MEM_AW must lie in 1..30");
   end

   xfer_state_e      state_q;
   logic [LAT_W-1:0] wait_q;
   logic [29:0]      addr_q;
   logic             flag_q;
   logic [31:0]      data_q;
   logic             start;
   logic             finish;

   assign busy   = (state_q != XF_IDLE);
   assign start  = xa_wr && !busy;
   assign finish = busy && (wait_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= XF_IDLE;
         wait_q  <= '0;
         addr_q  <= '0;
         flag_q  <= 1'b0;
      end else if (start) begin
         addr_q  <= xa_addr;
         flag_q  <= xa_flag;
         wait_q  <= lat_cfg;
         state_q <= xa_flag ? XF_STORE : XF_LOAD;
      end else if (finish) begin
         // Flag sense inverts on completion: store ends at 0, load at 1.
         flag_q  <= (state_q == XF_LOAD);
         state_q <= XF_IDLE;
      end else if (busy) begin
         wait_q  <= wait_q - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (finish && state_q == XF_LOAD) begin
         data_q <= mem_rdata;
      end else if (xd_wr && !busy) begin
         data_q <= xd_wdata;
      end
   end

   assign mem_we    = finish && (state_q == XF_STORE);
   assign mem_idx   = addr_q[MEM_AW-1:0];
   assign mem_wdata = data_q;
   assign xa_view   = {flag_q, 1'b0, addr_q};
   assign xd_view   = data_q;

   // Latency window tracked by a counter rather than a deep $past.
   logic [LAT_W:0] run_q;
   always_ff @(posedge clk) begin
      if (!rst_n) run_q <= '0;
      else        run_q <= busy ? run_q + 1'b1 : '0;
   end

   p_store_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == XF_STORE) |-> flag_q);
   p_load_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == XF_LOAD) |-> !flag_q);
   p_lat_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= (LAT_W+1)'(MAX_LAT));
   p_addr_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(addr_q));
   p_data_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !finish) |=> $stable(data_q));
endmodule

// File: rtl/cfgwin_space_mem.sv
module cfgwin_space_mem #(
   parameter int unsigned DEPTH      = 16,
   parameter bit          CLAIM_MODE = 1'b0,
   localparam int unsigned AW        = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] idx,
   input  logic [31:0]   wdata,
   output logic [31:0]   rdata
);
   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("cfgwin_space_mem: DEPTH must be a power of two >= 2");
   end

   logic [31:0] mem_q [DEPTH];

   assign rdata = mem_q[idx];

   if (CLAIM_MODE) begin : g_claim
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
         end else if (we && (mem_q[idx] == '0 || wdata == '0)) begin
            mem_q[idx] <= wdata;
         end
      end

      p_claim_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (we && rdata != '0 && wdata != '0) |=> mem_q[$past(idx)] == $past(rdata));
   end else begin : g_plain
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
         end else if (we) begin
            mem_q[idx] <= wdata;
         end
      end

      p_plain_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
         we |=> mem_q[$past(idx)] == $past(wdata));
   end
endmodule

// File: rtl/cfgwin_gateway.sv
module cfgwin_gateway
   import cfgwin_pkg::*;
#(
   parameter int unsigned          NUM_SPACES = 4,
   parameter logic [NUM_SPACES-1:0] SPACE_EN  = 4'b0111,
   parameter int unsigned          CLAIM_SPACE = 2,
   parameter int unsigned          MEM_DEPTH  = 16,
   parameter int unsigned          ID_W       = 32,
   parameter int unsigned          MAX_LAT    = 16,
   localparam int unsigned         MEM_AW     = $clog2(MEM_DEPTH),
   localparam int unsigned         LAT_W      = $clog2(MAX_LAT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LAT_W-1:0] lat_cfg,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic             req_write,
   input  logic [7:0]       req_offset,
   input  logic [31:0]      req_wdata,
   output logic             rsp_valid,
   output logic [31:0]      rsp_rdata
);
   if (NUM_SPACES < 1 || NUM_SPACES > 65536) begin : g_bad_ns
      $error("cfgwin_gateway: NUM_SPACES out of range");
   end
   if (CLAIM_SPACE >= NUM_SPACES) begin : g_bad_claim
      $error("cfgwin_gateway: CLAIM_SPACE must be a valid space");
   end

   logic acc_rd, acc_wr;
   assign req_ready = 1'b1;
   assign acc_rd    = req_valid && !req_write;
   assign acc_wr    = req_valid &&  req_write;

   // Space select and support status.
   logic [15:0] space_q;
   logic        space_ok;
   always_ff @(posedge clk) begin
      if (!rst_n)                                 space_q <= '0;
      else if (acc_wr && req_offset == OFF_SPACE) space_q <= req_wdata[15:0];
   end
   always_comb begin
      space_ok = 1'b0;
      for (int s = 0; s < NUM_SPACES; s++)
         if (space_q == 16'(s) && SPACE_EN[s]) space_ok = 1'b1;
   end

   // Ownership lock and tag counter.
   logic [ID_W-1:0] cnt_val;
   logic [31:0]     own_val;
   cfgwin_lock #(.ID_W(ID_W)) u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_rd    (acc_rd && req_offset == OFF_COUNT),
      .own_wr    (acc_wr && req_offset == OFF_OWNER),
      .own_wdata (req_wdata),
      .cnt_val   (cnt_val),
      .own_val   (own_val)
   );

   // Transfer engine.
   logic              busy, mem_we;
   logic [MEM_AW-1:0] mem_idx;
   logic [31:0]       mem_wdata, mem_rdata, xa_view, xd_view;
   logic              xa_wr;
   assign xa_wr = acc_wr && req_offset == OFF_XADDR;

   cfgwin_xfer #(.MEM_AW(MEM_AW), .MAX_LAT(MAX_LAT)) u_xfer (
      .clk       (clk),
      .rst_n     (rst_n),
      .lat_cfg   (lat_cfg),
      .xa_wr     (xa_wr),
      .xa_flag   (req_wdata[31]),
      .xa_addr   (req_wdata[29:0]),
      .xd_wr     (acc_wr && req_offset == OFF_XDATA),
      .xd_wdata  (req_wdata),
      .mem_rdata (mem_rdata),
      .busy      (busy),
      .mem_we    (mem_we),
      .mem_idx   (mem_idx),
      .mem_wdata (mem_wdata),
      .xa_view   (xa_view),
      .xd_view   (xd_view)
   );

   // Space captured at transfer start so later selects cannot redirect it.
   logic [15:0] act_space_q;
   always_ff @(posedge clk) begin
      if (!rst_n)             act_space_q <= '0;
      else if (xa_wr && !busy) act_space_q <= space_q;
   end

   logic [31:0] bank_rdata [NUM_SPACES];
   for (genvar s = 0; s < NUM_SPACES; s++) begin : g_bank
      if (SPACE_EN[s]) begin : g_on
         cfgwin_space_mem #(
            .DEPTH      (MEM_DEPTH),
            .CLAIM_MODE (s == CLAIM_SPACE)
         ) u_mem (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (mem_we && act_space_q == 16'(s)),
            .idx   (mem_idx),
            .wdata (mem_wdata),
            .rdata (bank_rdata[s])
         );
      end else begin : g_off
         assign bank_rdata[s] = '0;
      end
   end

   always_comb begin
      mem_rdata = '0;
      for (int s = 0; s < NUM_SPACES; s++)
         if (act_space_q == 16'(s)) mem_rdata = bank_rdata[s];
   end

   // Read mux and response.
   logic [31:0] rd_mux;
   always_comb begin
      unique case (req_offset)
         OFF_SPACE: rd_mux = {(space_ok ? ST_SUPPORTED : ST_UNSUPPORTED), 13'b0, space_q};
         OFF_COUNT: rd_mux = 32'(cnt_val);
         OFF_OWNER: rd_mux = own_val;
         OFF_XADDR: rd_mux = xa_view;
         OFF_XDATA: rd_mux = xd_view;
         default:   rd_mux = '0;
      endcase
   end

   logic        rsp_valid_q;
   logic [31:0] rsp_rdata_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid_q <= 1'b0;
         rsp_rdata_q <= '0;
      end else begin
         rsp_valid_q <= acc_rd;
         if (acc_rd) rsp_rdata_q <= rd_mux;
      end
   end
   assign rsp_valid = rsp_valid_q;
   assign rsp_rdata = rsp_rdata_q;

   p_rsp_after_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
      acc_rd |=> rsp_valid);
   p_rsp_none_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_rd |=> !rsp_valid);
   p_space_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(act_space_q));
endmodule

// File: tb/cfgwin_gateway_test.sv
`timescale 1ns/1ps
module cfgwin_gateway_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  lat_cfg = 4'd0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [7:0]  req_offset = 8'h00;
   logic [31:0] req_wdata = '0;
   logic        req_ready;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;

   always #2 clk = ~clk;

   cfgwin_gateway #(.ID_W(4)) uut (
      .clk(clk), .rst_n(rst_n), .lat_cfg(lat_cfg),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_offset(req_offset), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
   );

   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;
   logic [31:0] exp_q [$];
   string       tag_q [$];

   // Scoreboard monitor.
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         n_chk++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R12 unexpected response got %h expected none", rsp_rdata);
         end else begin
            logic [31:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (rsp_rdata !== e) begin
               n_bad++;
               $display("FAIL %s got %h expected %h", t, rsp_rdata, e);
            end
         end
      end
      if (rst_n) begin
         n_chk++;
         if (req_ready !== 1'b1) begin
            n_bad++;
            $display("FAIL R12 req_ready got %b expected 1", req_ready);
         end
      end
   end

   task automatic wr(input logic [7:0] off, input logic [31:0] d);
      req_valid = 1'b1; req_write = 1'b1; req_offset = off; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic rd(input logic [7:0] off, input logic [31:0] e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      req_valid = 1'b1; req_write = 1'b0; req_offset = off;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic mstore(input logic [29:0] a, input logic [31:0] d);
      wr(8'h14, d);
      wr(8'h10, {2'b10, a});
      idle(20);
   endtask

   task automatic mload(input logic [29:0] a, input logic [31:0] e, input string t);
      wr(8'h10, {2'b00, a});
      idle(20);
      rd(8'h14, e, t);
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : stim
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // Reset state
      rd(8'h0C, 32'h0, "R2 owner after reset");
      rd(8'h04, 32'h2000_0000, "R4 space after reset");
      rd(8'h10, 32'h0, "R5 xaddr after reset");
      rd(8'h00, 32'h0, "R12 unmapped 0x00");
      rd(8'h18, 32'h0, "R12 unmapped 0x18");
      wr(8'h08, 32'h5);          // counter write has no effect
      idle(2);

      // R1: tag 1..15 then wrap to 1
      for (int i = 1; i <= 15; i++) rd(8'h08, 32'(i), "R1 tag sequence");
      rd(8'h08, 32'h1, "R1 tag wrap skips zero");

      // R2 / R3: ownership
      wr(8'h0C, 32'h2);
      rd(8'h0C, 32'h2, "R2 owner taken");
      wr(8'h0C, 32'h9);
      rd(8'h0C, 32'h2, "R3 conflicting tag ignored");
      wr(8'h0C, 32'h0);
      rd(8'h0C, 32'h0, "R3 release");
      wr(8'h0C, 32'h9);
      rd(8'h0C, 32'h9, "R2 second owner");
      wr(8'h0C, 32'h0);

      // R4: space select/status
      wr(8'h04, 32'h1);
      rd(8'h04, 32'h2000_0001, "R4 space 1 supported");
      wr(8'h04, 32'h3);
      rd(8'h04, 32'h0000_0003, "R4 space 3 unsupported");
      wr(8'h04, 32'h0100);
      rd(8'h04, 32'h0000_0100, "R4 space 0x100 unsupported");
      wr(8'h04, 32'hFFFF_0002);
      rd(8'h04, 32'h2000_0002, "R4 upper bits not stored");

      // R5 / R7: store at latency 4, polled every cycle
      wr(8'h04, 32'h1);
      lat_cfg = 4'd3;
      wr(8'h14, 32'hA5A5_0001);
      wr(8'h10, 32'h8000_0005);
      for (int k = 1; k <= 4; k++) rd(8'h10, 32'h8000_0005, "R7 store pending lat4");
      rd(8'h10, 32'h0000_0005, "R5 store flag cleared");

      // R6 / R7: load at latency 4
      wr(8'h10, 32'h0000_0005);
      for (int k = 1; k <= 4; k++) rd(8'h10, 32'h0000_0005, "R7 load pending lat4");
      rd(8'h10, 32'h8000_0005, "R6 load flag set");
      rd(8'h14, 32'hA5A5_0001, "R6 load data");

      // R7: shortest latency
      lat_cfg = 4'd0;
      wr(8'h14, 32'h0000_0777);
      wr(8'h10, 32'h8000_0007);
      rd(8'h10, 32'h8000_0007, "R7 store pending lat1");
      rd(8'h10, 32'h0000_0007, "R7 store done lat1");

      // R7: longest latency
      lat_cfg = 4'd15;
      wr(8'h10, 32'h0000_0007);
      for (int k = 1; k <= 16; k++) rd(8'h10, 32'h0000_0007, "R7 load pending lat16");
      rd(8'h10, 32'h8000_0007, "R7 load done lat16");
      rd(8'h14, 32'h0000_0777, "R7 load data lat16");

      // R10: writes while pending are ignored
      wr(8'h14, 32'h0000_3333);
      wr(8'h10, 32'h8000_0002);
      wr(8'h14, 32'h0000_4444);
      wr(8'h10, 32'h0000_0009);
      rd(8'h10, 32'h8000_0002, "R10 xaddr unchanged while pending");
      idle(20);
      rd(8'h14, 32'h0000_3333, "R10 data unchanged");
      rd(8'h10, 32'h0000_0002, "R10 original store completed");
      lat_cfg = 4'd2;
      mload(30'h2, 32'h0000_3333, "R10 stored word intact");

      // R11: independent spaces, address aliasing
      wr(8'h04, 32'h0);
      mstore(30'h5, 32'h0000_1111);
      mload(30'h5, 32'h0000_1111, "R11 space 0 word");
      wr(8'h04, 32'h1);
      mload(30'h5, 32'hA5A5_0001, "R11 space 1 word independent");
      mload(30'h15, 32'hA5A5_0001, "R11 upper address bits ignored");

      // R8: unsupported spaces
      wr(8'h04, 32'h3);
      mstore(30'h5, 32'hDEAD_BEEF);
      rd(8'h10, 32'h0000_0005, "R8 store completes in unsupported space");
      mload(30'h5, 32'h0, "R8 load returns zero space 3");
      rd(8'h10, 32'h8000_0005, "R8 load completes in unsupported space");
      wr(8'h04, 32'h0100);
      mload(30'h5, 32'h0, "R8 load returns zero space 0x100");
      wr(8'h04, 32'h1);
      mload(30'h5, 32'hA5A5_0001, "R8 dropped store left space 1 intact");

      // R9: claim domain versus ordinary space
      wr(8'h04, 32'h2);
      mstore(30'h3, 32'h7);
      mload(30'h3, 32'h7, "R9 claim taken");
      mstore(30'h3, 32'h9);
      mload(30'h3, 32'h7, "R9 conflicting claim ignored");
      mstore(30'h3, 32'h0);
      mload(30'h3, 32'h0, "R9 claim freed");
      mstore(30'h3, 32'h9);
      mload(30'h3, 32'h9, "R9 new claim");
      wr(8'h04, 32'h0);
      mstore(30'h5, 32'h0000_0022);
      mload(30'h5, 32'h0000_0022, "R9 ordinary space overwrites");

      idle(5);
      n_chk++;
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL R12 missing responses got %0d pending expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule